// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of general-purpose input pins and turns a chosen condition on each pin into a sticky interrupt flag. Every pin has a control word that holds a 4-bit trigger code. The code selects one of five conditions: level low, level high, rising edge, falling edge or either edge. Any other code turns the pin's detection off. Pins are brought into the clock domain through a synchronizer chain before any condition is evaluated. Edges are found by comparing the synchronized value with its value one cycle earlier.

Flags for all pins sit together in one status word. Software clears a flag by writing 1 to its bit, and a single request line is raised while any flag is set. Software reaches the control words and the status word over a plain memory-mapped register bus. A write is taken on the rising clock edge where the write strobe is high. Read data is a combinational function of the address and has no side effects. The control and status pins carry no handshake, so there is no back-pressure on this interface.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted, and right after it is released, every control word reads 0, the status word reads 0 and `irq_o` is low.
- R2: The control word of pin n sits at byte address 4·n. Its trigger code is written through, and reads back in, bits 19:16. Every other bit of a control word reads 0, and an address that maps to no register reads 0.
- R3: Code 0x8 (level low) sets the pin's flag on every cycle in which the synchronized pin is 0.
- R4: Code 0xC (level high) sets the pin's flag on every cycle in which the synchronized pin is 1.
- R5: Code 0x9 (rising edge) sets the flag only when the synchronized pin goes from 0 to 1.
- R6: Code 0xA (falling edge) sets the flag only when the synchronized pin goes from 1 to 0.
- R7: Code 0xB (either edge) sets the flag on every change of the synchronized pin.
- R8: Code 0x0, and any code outside 0x8, 0x9, 0xA, 0xB and 0xC, never sets the pin's flag.
- R9: The status word is at byte address 0xA0, with bit n holding the flag of pin n. Writing 1 to a bit clears that flag. Bits written as 0 are left unchanged, and writing all ones clears every flag. Flags never clear in any other way.
- R10: If a detection and a clearing write hit the same bit in the same cycle, the flag stays set. A level-mode flag therefore survives a clear for as long as its level remains.
- R11: `irq_o` is high exactly when at least one status flag is set.
- R12: Suppose a pin changes just after clock edge E. With SYNC_STAGES = 2, its flag is visible from edge E+3 (SYNC_STAGES+1 edges later) and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS (32) | Asynchronous pin levels |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | ADDR_W (8) | Byte address for reads and writes |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives every input 2 ns after a rising edge and compares outputs on the falling edge. Each comparison therefore sees the settled result of the edge before it.

A pin change becomes a flag, and `irq_o` follows it, SYNC_STAGES+1 rising edges after the change. Writes to control or status words take effect on the edge where the strobe is sampled. Read data follows the address in the same cycle.

The reference model keeps a queue of the pin values sampled at each edge. It reads the current and previous synchronized levels from fixed depths in that queue, so every output is compared in the exact cycle it is due. Directed checks probe the one cycle before and the one cycle after the flag edge.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 16;

  typedef enum logic [CODE_W-1:0] {
    TRIG_OFF  = 4'h0,
    TRIG_LOW  = 4'h8,
    TRIG_RISE = 4'h9,
    TRIG_FALL = 4'hA,
    TRIG_BOTH = 4'hB,
    TRIG_HIGH = 4'hC
  } trig_e;

  // True for the codes that select a detection condition.
  function automatic logic trig_supported(input logic [CODE_W-1:0] code);
    case (code)
      TRIG_LOW, TRIG_RISE, TRIG_FALL, TRIG_BOTH, TRIG_HIGH: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Condition met this cycle, given the current and previous synchronized level.
  function automatic logic trig_hit(input logic [CODE_W-1:0] code,
                                    input logic cur, input logic prev);
    case (code)
      TRIG_LOW:  return ~cur;
      TRIG_HIGH: return cur;
      TRIG_RISE: return cur & ~prev;
      TRIG_FALL: return ~cur & prev;
      TRIG_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        cur_i,
  input  logic [NPINS*CODE_W-1:0] cfg_flat_i,
  output logic [NPINS-1:0]        evt_o
);

  logic [NPINS-1:0] prev_q;

  // One-cycle history of the synchronized levels for edge comparison.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign evt_o[i] = trig_hit(cfg_flat_i[i*CODE_W +: CODE_W], cur_i[i], prev_q[i]);
  end

endmodule

// File: rtl/gpio_cfg_bank.sv
`timescale 1ns/1ps
module gpio_cfg_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [CODE_W-1:0]       code_i,
  output logic [NPINS*CODE_W-1:0] cfg_flat_o,
  output logic                    rd_hit_o,
  output logic [CODE_W-1:0]       rd_code_o
);

  localparam int IDX_W = ADDR_W - 2;

  logic              aligned;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] code_q [NPINS];

  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx     = addr_i[ADDR_W-1:2];

  for (genvar i = 0; i < NPINS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[i] <= '0;
      else if (wr_i && aligned && (idx == IDX_W'(i)))
        code_q[i] <= code_i;
    end
    assign cfg_flat_o[i*CODE_W +: CODE_W] = code_q[i];
  end

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_code_o = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (aligned && (idx == IDX_W'(i))) begin
        rd_hit_o  = 1'b1;
        rd_code_o = code_q[i];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int               NPINS       = 32,
  parameter int               SYNC_STAGES = 2,
  parameter int               ADDR_W      = 8,
  parameter int               DATA_W      = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS   = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic [NPINS-1:0]        pin_s;
  logic [NPINS-1:0]        evt;
  logic [NPINS*CODE_W-1:0] cfg_flat;
  logic                    cfg_hit;
  logic [CODE_W-1:0]       cfg_code;
  logic [NPINS-1:0]        status_q;
  logic                    addr_is_stat;
  logic [NPINS-1:0]        clr_mask;

  gpio_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .cur_i(pin_s), .cfg_flat_i(cfg_flat), .evt_o(evt)
  );

  gpio_cfg_bank #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .code_i(bus_wdata_i[CODE_LSB +: CODE_W]), .cfg_flat_o(cfg_flat),
    .rd_hit_o(cfg_hit), .rd_code_o(cfg_code)
  );

  assign addr_is_stat = (bus_addr_i == STAT_OFS);
  assign clr_mask     = (bus_wr_i && addr_is_stat) ? bus_wdata_i[NPINS-1:0] : '0;

  // Detection is applied after the clear so that a same-cycle event wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | evt;
  end

  assign irq_o = |status_q;

  always_comb begin
    bus_rdata_o = '0;
    if (addr_is_stat)
      bus_rdata_o = DATA_W'(status_q);
    else if (cfg_hit)
      bus_rdata_o[CODE_LSB +: CODE_W] = cfg_code;
  end

endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int                NPINS    = 32,
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'hA0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr_i,
  input logic [ADDR_W-1:0]       bus_addr_i,
  input logic [DATA_W-1:0]       bus_wdata_i,
  input logic [NPINS-1:0]        status_q,
  input logic [NPINS-1:0]        evt,
  input logic [NPINS*CODE_W-1:0] cfg_flat,
  input logic                    irq_o
);

  logic             stat_wr;
  logic [NPINS-1:0] wmask;

  assign stat_wr = bus_wr_i && (bus_addr_i == STAT_OFS);
  assign wmask   = bus_wdata_i[NPINS-1:0];

  always @(negedge clk) begin
    if (rst_n == 1'b0) begin
      // R1
      reset_clear_chk: assert (status_q == '0 && irq_o == 1'b0);
    end
  end

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((status_q & $past(wmask & ~evt)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

  // R11
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(stat_wr));

  for (genvar i = 0; i < NPINS; i++) begin : g_code
    // R8
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_supported(cfg_flat[i*CODE_W +: CODE_W]) |-> !evt[i]);
  end

endmodule

bind gpio_irq_detect gpio_irq_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .status_q(status_q), .evt(evt),
  .cfg_flat(cfg_flat), .irq_o(irq_o)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;

  localparam int NP   = 32;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'hA0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_detect u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [NP-1:0] hist[$];
  int            m_code[NP];
  logic [NP-1:0] m_stat;
  logic [NP-1:0] cur, prv, ev, clr;
  bit            m_ok = 1'b0;

  function automatic bit fire(input int code, input bit c, input bit p);
    case (code)
      8:  return !c;
      12: return c;
      9:  return c && !p;
      10: return !c && p;
      11: return c != p;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int k = 0; k < SYNC + 2; k++) hist.push_back('0);
      for (int k = 0; k < NP; k++) m_code[k] = 0;
      m_stat = '0;
      m_ok = 1'b1;
    end else begin
      hist.push_front(pin);
      cur = hist[SYNC];
      prv = hist[SYNC+1];
      for (int k = 0; k < NP; k++) ev[k] = fire(m_code[k], cur[k], prv[k]);
      clr = (bus_wr && bus_addr == 8'hA0) ? bus_wdata : '0;
      m_stat = (m_stat & ~clr) | ev;
      if (bus_wr && bus_addr < 8'h80 && bus_addr[1:0] == 2'b00)
        m_code[bus_addr >> 2] = int'(bus_wdata[19:16]);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    if (a == 8'hA0) return m_stat;
    if (a < 8'h80 && a[1:0] == 2'b00) return 32'(m_code[a >> 2]) << 16;
    return '0;
  endfunction

  // Per-cycle comparison on the falling edge.
  always @(negedge clk) begin
    if (rst_n && m_ok && !done) begin
      chk(irq == (m_stat != '0), "R11 irq vs model", 32'(irq), 32'(m_stat != '0));
      chk(bus_rdata == model_rd(bus_addr), "R12 read data vs model", bus_rdata, model_rd(bus_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = 8'hA0; bus_wdata = '0;
  endtask

  task automatic setpin(input int n, input bit v);
    @(posedge clk); #2;
    pin[n] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rd_at(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
    bus_addr = 8'hA0; #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int codes[8] = '{0, 8, 9, 10, 11, 12, 5, 15};

    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(bus_rdata == 0 && irq == 0, "R1 status/irq in reset", bus_rdata, 0);
    #1 rst_n = 1'b1;
    idle(2);
    rd_at(8'h0C, d);
    chk(d == 0, "R1 control word after reset", d, 0);
    chk(irq == 0, "R1 irq after reset", 32'(irq), 0);

    // R2: control word layout
    wr(8'h0C, 32'h0009_FFFF);
    rd_at(8'h0C, d);
    chk(d == 32'h0009_0000, "R2 code readback pin3", d, 32'h0009_0000);
    rd_at(8'h0D, d);
    chk(d == 0, "R2 unaligned address reads 0", d, 0);

    // R12 + R5: latency of a rising edge on pin 3
    setpin(3, 1'b1);
    @(posedge clk); @(posedge clk); #1;
    chk(bus_rdata[3] == 1'b0, "R12 flag not yet set at E+2", bus_rdata, 0);
    @(posedge clk); #1;
    chk(bus_rdata[3] == 1'b1, "R12 R5 flag set at E+3", bus_rdata, 32'h8);
    chk(irq == 1'b1, "R11 irq high with flag", 32'(irq), 1);

    // R9: zero write leaves flags, one clears
    wr(8'hA0, 32'h0);
    chk(bus_rdata[3] == 1'b1, "R9 writing 0 keeps flag", bus_rdata, 32'h8);
    wr(8'hA0, 32'h8);
    chk(bus_rdata[3] == 1'b0, "R9 writing 1 clears flag", bus_rdata, 0);
    chk(irq == 1'b0, "R11 irq low with no flags", 32'(irq), 0);
    setpin(3, 1'b0);
    idle(6);
    chk(bus_rdata[3] == 1'b0, "R5 falling does not set rising pin", bus_rdata, 0);

    // R6: falling edge on pin 4
    wr(8'h10, 32'h000A_0000);
    setpin(4, 1'b1);
    idle(6);
    chk(bus_rdata[4] == 1'b0, "R6 rising ignored", bus_rdata, 0);
    setpin(4, 1'b0);
    idle(6);
    chk(bus_rdata[4] == 1'b1, "R6 falling sets flag", bus_rdata, 32'h10);
    wr(8'hA0, 32'h10);

    // R7: either edge on pin 5
    wr(8'h14, 32'h000B_0000);
    setpin(5, 1'b1);
    idle(6);
    chk(bus_rdata[5] == 1'b1, "R7 rise sets flag", bus_rdata, 32'h20);
    wr(8'hA0, 32'h20);
    setpin(5, 1'b0);
    idle(6);
    chk(bus_rdata[5] == 1'b1, "R7 fall sets flag", bus_rdata, 32'h20);
    wr(8'hA0, 32'h20);

    // R4 + R10: level high on pin 6 survives a clear
    wr(8'h18, 32'h000C_0000);
    setpin(6, 1'b1);
    idle(6);
    chk(bus_rdata[6] == 1'b1, "R4 level high sets flag", bus_rdata, 32'h40);
    wr(8'hA0, 32'h40);
    chk(bus_rdata[6] == 1'b1, "R10 set wins over clear", bus_rdata, 32'h40);
    setpin(6, 1'b0);
    idle(6);
    wr(8'hA0, 32'h40);
    chk(bus_rdata[6] == 1'b0, "R4 clear holds once level gone", bus_rdata, 0);

    // R3: level low on pin 7 (pin idles low)
    wr(8'h1C, 32'h0008_0000);
    idle(6);
    chk(bus_rdata[7] == 1'b1, "R3 level low sets flag", bus_rdata, 32'h80);
    setpin(7, 1'b1);
    idle(6);
    wr(8'hA0, 32'h80);
    chk(bus_rdata[7] == 1'b0, "R3 clear holds once pin high", bus_rdata, 0);

    // R8: unsupported and zero codes
    wr(8'h20, 32'h0005_0000);
    wr(8'h24, 32'h0000_0000);
    wr(8'h28, 32'h000F_0000);
    for (int t = 0; t < 4; t++) begin
      setpin(8, ~pin[8]); setpin(9, ~pin[9]); setpin(10, ~pin[10]);
      idle(3);
    end
    idle(4);
    chk(bus_rdata[10:8] == 3'b000, "R8 disabled codes never flag", bus_rdata, 0);
    chk(irq == 1'b0, "R8 irq stays low", 32'(irq), 0);

    // R9: all-ones write clears several flags
    setpin(5, 1'b1);
    setpin(3, 1'b1);
    idle(6);
    chk(bus_rdata[5] && bus_rdata[3], "R9 two flags set", bus_rdata, 32'h28);
    wr(8'hA0, 32'hFFFF_FFFF);
    chk(bus_rdata == 0, "R9 all ones clears all", bus_rdata, 0);

    // Random phase: model comparison every cycle
    for (int p = 0; p < NP; p++) wr(8'(p * 4), 32'(codes[$urandom_range(0, 7)]) << 16);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int r;
      @(posedge clk); #2;
      pin = pin ^ ($urandom() & $urandom() & $urandom());
      r = $urandom_range(0, 19);
      bus_wr = 1'b0; bus_wdata = '0;
      if (r < 2) begin
        bus_wr = 1'b1;
        bus_addr = 8'($urandom_range(0, NP - 1) * 4);
        bus_wdata = 32'(codes[$urandom_range(0, 7)]) << 16;
      end else if (r < 4) begin
        bus_wr = 1'b1;
        bus_addr = 8'hA0;
        bus_wdata = $urandom();
      end else if (r < 8) begin
        bus_addr = 8'($urandom_range(0, 255));
      end else begin
        bus_addr = 8'hA0;
      end
    end
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = 8'hA0;
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule